// File: doc/BRIEF.md
# Combined Dual-LFSR Pseudorandom Bit Generator

This block produces a pseudorandom bit stream from two maximal-length linear-feedback shift registers of different lengths, a 4-bit register and a 6-bit register, run in lockstep. Each register shifts one place towards its most significant bit on every enabled clock edge. The freed low bit takes the XOR of the bit leaving the top and one fixed tap. The output bit is the XOR of the two top bits. The two register periods, 15 and 63, share only the factor 3, so the combined stream repeats every 315 enabled steps.

A design uses the block as a cheap test-pattern or dither source. `en_i` paces the stream. Each register has its own seed-load port. A zero seed is replaced with the register's default seed, so the all-zeros lock-up state can never be entered. `wrap_o` pulses once each time the combined sequence returns to its starting point. The deassertion of `rst_ni` is expected to be synchronous to `clk_i`.

Top module: `dual_lfsr_mix`

## Requirements
- R1: While `rst_ni` is low, and right after it is released, `state_a_o` = 4'b0001, `state_b_o` = 6'b000001 and `wrap_o` = 0. Reset acts at once, without waiting for a clock edge.
- R2: On an enabled edge without `load_a_i`, register A becomes {a[2:0], a[3]^a[2]}. Its state sequence has period 15.
- R3: On an enabled edge without `load_b_i`, register B becomes {b[4:0], b[5]^b[4]}. Its state sequence has period 63.
- R4: `bit_o` always equals `state_a_o[3] ^ state_b_o[5]`.
- R5: `wrap_o` is 1 for exactly the one cycle that follows an enabled edge with neither load active after which A = 4'b0001 and B = 6'b000001. Starting from reset with no loads, this happens every 315 enabled steps.
- R6: Neither `state_a_o` nor `state_b_o` is ever all zeros.
- R7: With `en_i` low and no load active, both registers hold their values across an edge, and `wrap_o` is 0 after that edge.
- R8: A load takes the matching seed port on the next edge, whatever `en_i` is. The register that is not loaded still steps if `en_i` is high.
- R9: A load whose seed is all zeros puts that register's default seed (4'b0001 or 6'b000001) in its place.
- R10: An edge on which either load is active never raises `wrap_o` on the following cycle, even when the loaded values equal the seeds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Step enable for both registers |
| load_a_i | input | 1 | Load seed_a_i into register A |
| seed_a_i | input | 4 | Seed value for register A |
| load_b_i | input | 1 | Load seed_b_i into register B |
| seed_b_i | input | 6 | Seed value for register B |
| bit_o | output | 1 | Combined pseudorandom bit |
| state_a_o | output | 4 | Current state of register A |
| state_b_o | output | 6 | Current state of register B |
| wrap_o | output | 1 | One-cycle pulse when the combined sequence restarts |

## Verification
On every cycle the assertions check the following:
- neither register is zero;
- held registers stay stable;
- the upper bits of a stepping register are the previous lower bits;
- loads, including zero seeds, land as specified;
- a wrap pulse lasts one cycle, finds both registers at their seeds and never follows a load.

Only the bench's long runs can show the things no single-cycle property sees: the 15 and 63 periods, the 315-step spacing of the wrap pulse, and the full feedback value bit by bit. Its per-cycle reference model compares all four outputs through enabled runs, idle stretches, mixed loads and a mid-run reset.

// File: rtl/dlmix_pkg.sv
package dlmix_pkg;
  // Register A: 4 bits, feedback from bits 3 and 2
  localparam int unsigned A_W_DEF   = 4;
  localparam int unsigned A_TAP_DEF = 2;
  // Register B: 6 bits, feedback from bits 5 and 4
  localparam int unsigned B_W_DEF   = 6;
  localparam int unsigned B_TAP_DEF = 4;
endpackage

// File: rtl/lfsr_shift_core.sv
module lfsr_shift_core #(
  parameter int unsigned W    = 4,
  parameter int unsigned TAP  = 2,
  parameter logic [W-1:0] SEED = {{(W-1){1'b0}}, 1'b1}
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  output logic [W-1:0] state_o,
  output logic         seed_next_o
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] state_q, state_d, stepped, seed_sel;
  logic         fb;
  logic         upd;

  // next-state logic
  always_comb begin
    fb       = state_q[MSB] ^ state_q[TAP];
    stepped  = {state_q[MSB-1:0], fb};
    seed_sel = (seed_i == '0) ? SEED : seed_i;
    upd      = load_i | step_i;
    state_d  = state_q;
    if (load_i)      state_d = seed_sel;
    else if (step_i) state_d = stepped;
  end

  // register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  state_q <= SEED;
    else if (upd) state_q <= state_d;
  end

  assign state_o     = state_q;
  assign seed_next_o = (state_d == SEED);

  // R6
  nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(state_q));
  // R2 R3
  shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> state_q[MSB:1] == $past(state_q[MSB-1:0]));
  // R8
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && seed_i != '0) |=> state_q == $past(seed_i));
  // R9
  zero_seed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && seed_i == '0) |=> state_q == SEED);
endmodule

// File: rtl/lfsr_wrap_det.sv
module lfsr_wrap_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic any_load_i,
  input  logic a_seed_next_i,
  input  logic b_seed_next_i,
  output logic wrap_o
);
  logic wrap_q, wrap_d;

  always_comb begin
    wrap_d = en_i & ~any_load_i & a_seed_next_i & b_seed_next_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wrap_q <= 1'b0;
    else         wrap_q <= wrap_d;
  end

  assign wrap_o = wrap_q;

  // R5
  wrap_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_q |=> !wrap_q);
  // R10
  wrap_no_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_load_i |=> !wrap_q);
endmodule

// File: rtl/dual_lfsr_mix.sv
module dual_lfsr_mix #(
  parameter int unsigned A_W   = dlmix_pkg::A_W_DEF,
  parameter int unsigned A_TAP = dlmix_pkg::A_TAP_DEF,
  parameter int unsigned B_W   = dlmix_pkg::B_W_DEF,
  parameter int unsigned B_TAP = dlmix_pkg::B_TAP_DEF
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           load_a_i,
  input  logic [A_W-1:0] seed_a_i,
  input  logic           load_b_i,
  input  logic [B_W-1:0] seed_b_i,
  output logic           bit_o,
  output logic [A_W-1:0] state_a_o,
  output logic [B_W-1:0] state_b_o,
  output logic           wrap_o
);
  localparam logic [A_W-1:0] A_SEED = {{(A_W-1){1'b0}}, 1'b1};
  localparam logic [B_W-1:0] B_SEED = {{(B_W-1){1'b0}}, 1'b1};

  logic a_seed_nxt, b_seed_nxt;

  lfsr_shift_core #(.W(A_W), .TAP(A_TAP), .SEED(A_SEED)) u_reg_a (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (en_i),
    .load_i     (load_a_i),
    .seed_i     (seed_a_i),
    .state_o    (state_a_o),
    .seed_next_o(a_seed_nxt)
  );

  lfsr_shift_core #(.W(B_W), .TAP(B_TAP), .SEED(B_SEED)) u_reg_b (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (en_i),
    .load_i     (load_b_i),
    .seed_i     (seed_b_i),
    .state_o    (state_b_o),
    .seed_next_o(b_seed_nxt)
  );

  lfsr_wrap_det u_wrap (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .any_load_i   (load_a_i | load_b_i),
    .a_seed_next_i(a_seed_nxt),
    .b_seed_next_i(b_seed_nxt),
    .wrap_o       (wrap_o)
  );

  assign bit_o = state_a_o[A_W-1] ^ state_b_o[B_W-1];

  // R5
  wrap_at_seed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |-> (state_a_o == A_SEED && state_b_o == B_SEED));
endmodule

// File: tb/dual_lfsr_mix_tb.sv
module dual_lfsr_mix_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en, ld_a, ld_b;
  logic [3:0] sd_a;
  logic [5:0] sd_b;
  logic       bit_w, wrap_w;
  logic [3:0] st_a;
  logic [5:0] st_b;

  int checks = 0;
  int errors = 0;
  int m_a, m_b;         // reference model states
  bit m_wrap;
  int step_no, last_a, last_b, last_w;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  dual_lfsr_mix u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .load_a_i(ld_a), .seed_a_i(sd_a), .load_b_i(ld_b), .seed_b_i(sd_b),
    .bit_o(bit_w), .state_a_o(st_a), .state_b_o(st_b), .wrap_o(wrap_w)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk("R2 state_a", int'(st_a), m_a);
    chk("R3 state_b", int'(st_b), m_b);
    chk("R4 bit_o", int'(bit_w), ((m_a >> 3) ^ (m_b >> 5)) & 1);
    chk("R5 wrap_o", int'(wrap_w), int'(m_wrap));
    chk("R6 a_nonzero", int'(st_a != 0), 1);
    chk("R6 b_nonzero", int'(st_b != 0), 1);
  endtask

  // one clock step; inputs driven after negedge, outputs sampled at next negedge
  task automatic step(input bit e, input bit la, input int sa,
                      input bit lb, input int sb);
    int na, nb;
    en = e; ld_a = la; sd_a = 4'(sa); ld_b = lb; sd_b = 6'(sb);
    @(posedge clk);
    na = m_a; nb = m_b;
    if (la)     na = (sa == 0) ? 1 : sa;
    else if (e) na = ((m_a * 2) % 16) + (((m_a / 8) + (m_a / 4)) % 2);
    if (lb)     nb = (sb == 0) ? 1 : sb;
    else if (e) nb = ((m_b * 2) % 64) + (((m_b / 32) + (m_b / 16)) % 2);
    m_wrap = e && !la && !lb && na == 1 && nb == 1;
    m_a = na; m_b = nb;
    @(negedge clk);
    cmp_all();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 0; ld_a = 0; ld_b = 0; sd_a = 0; sd_b = 0;
    m_a = 1; m_b = 1; m_wrap = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset a", int'(st_a), 1);
    chk("R1 reset b", int'(st_b), 1);
    chk("R1 reset wrap", int'(wrap_w), 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_all();

    // R2 R3 R5: long enabled run, measure periods
    step_no = 0; last_a = 0; last_b = 0; last_w = 0;
    for (int i = 0; i < 700; i++) begin
      step(1, 0, 0, 0, 0);
      step_no++;
      if (m_a == 1) begin chk("R2 period_a", step_no - last_a, 15); last_a = step_no; end
      if (m_b == 1) begin chk("R3 period_b", step_no - last_b, 63); last_b = step_no; end
      if (wrap_w)   begin chk("R5 wrap_interval", step_no - last_w, 315); last_w = step_no; end
    end
    chk("R5 wrap_seen", last_w, 630);

    // R7 idle: hold
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 0);

    // R8 loads, with and without enable
    step(0, 1, 10, 1, 38);
    chk("R8 load_a", int'(st_a), 10);
    chk("R8 load_b", int'(st_b), 38);
    step(1, 1, 5, 0, 0);   // A loaded, B steps
    chk("R8 load_a_en", int'(st_a), 5);
    step(1, 0, 0, 1, 17);  // B loaded, A steps
    chk("R8 load_b_en", int'(st_b), 17);
    for (int i = 0; i < 40; i++) step(1, 0, 0, 0, 0);

    // R9 zero seeds
    step(1, 1, 0, 1, 0);
    chk("R9 zero_a", int'(st_a), 1);
    chk("R9 zero_b", int'(st_b), 1);

    // R10 load to seeds: no wrap
    step(1, 1, 1, 1, 1);
    chk("R10 no_wrap_load", int'(wrap_w), 0);
    step(0, 1, 1, 1, 1);
    chk("R10 no_wrap_load_idle", int'(wrap_w), 0);

    // mixed enable pattern
    for (int i = 0; i < 400; i++) step(bit'((i % 3) != 0), 0, 0, 0, 0);

    // R1 asynchronous reset mid-run
    for (int i = 0; i < 7; i++) step(1, 0, 0, 0, 0);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R1 async a", int'(st_a), 1);
    chk("R1 async b", int'(st_b), 1);
    chk("R1 async wrap", int'(wrap_w), 0);
    m_a = 1; m_b = 1; m_wrap = 0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 320; i++) step(1, 0, 0, 0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule